// File: doc/BRIEF.md
# Branch Trace Record Store Engine

This engine turns a stream of control-flow events into fixed-size records in a circular trace buffer in memory. There are two kinds of event. A branch event carries a source address and a destination address. An informational event carries an 8-bit type code and a data word. The engine builds each record in place and writes it through a word-wide memory write port with a valid/ready handshake. When the record is complete, the engine moves its write pointer forward.

Four pointer registers describe the buffer: the base address, the current write pointer, the end address (one byte past the last buffer byte) and an interrupt threshold. The write pointer wraps from the end back to the base. A sticky interrupt is raised when the pointer crosses the threshold.

A layout-select input chooses between two layouts. In the narrow layout, fields and pointers are 32 bits and a record is 12 bytes. In the wide layout, fields and pointers are 64 bits and a record is 24 bytes.

Top module: `btrs_engine`

## Requirements
- R1: After reset, `busy`, `irq` and `memValid` are 0 and `writePtr` reads 0.
- R2: An event is taken only when `evValid` is high while `busy` is low. `busy` then stays high until every word of the record has been accepted and the pointer has been updated. `evValid` pulses seen while `busy` is high start no record.
- R3: A narrow branch record is 3 words, sent in order: source[31:0], destination[31:0], 0.
- R4: A wide branch record is 6 words, sent in order: source low, source high, destination low, destination high, 0, 0.
- R5: An informational record fills field 0 with all ones (the escape marker). Field 1 holds the type code zero-extended, so the type is the lowest byte of that field. Field 2 holds the data word, truncated to 32 bits in the narrow layout. Every other byte is 0. Field k occupies words k (narrow) or 2k and 2k+1 (wide), lower word first.
- R6: Word k of a record goes to byte address `writePtr + 4*k`. Address and data stay stable while `memValid` is high and `memReady` is low.
- R7: After each record, the pointer becomes `writePtr + recordBytes` (12 narrow, 24 wide). If that value is greater than or equal to the end address, the pointer becomes the base instead.
- R8: `irq` is set when the old pointer is below the threshold, the advanced (pre-wrap) pointer is at or above it, and the threshold is not above the end address. A threshold beyond the end therefore never fires.
- R9: `irq` stays high until an `irqClr` pulse clears it. A new crossing in the same cycle wins over the clear.
- R10: A `cfgWe` pulse writes `cfgData` into the register picked by `cfgSel` (0 base, 1 write pointer, 2 end, 3 threshold). It takes effect only while `busy` is low and is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| layoutWide | input | 1 | 1 = wide layout, 0 = narrow; latched with each event |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Register select: 0 base, 1 pointer, 2 end, 3 threshold |
| cfgData | input | 64 | Configuration write value |
| evValid | input | 1 | Event present |
| evInfo | input | 1 | 1 = informational event, 0 = branch |
| evSrc | input | 64 | Branch source address |
| evDst | input | 64 | Branch destination address |
| evType | input | 8 | Informational type code |
| evData | input | 64 | Informational data word |
| irqClr | input | 1 | Clears the sticky interrupt |
| memReady | input | 1 | Memory accepts the current word |
| memValid | output | 1 | Word write request |
| memAddr | output | 64 | Byte address of the word |
| memData | output | 32 | Word data |
| busy | output | 1 | Record in progress |
| irq | output | 1 | Sticky threshold interrupt |
| writePtr | output | 64 | Current write pointer |

## Verification
The bench keeps the default widths: 64-bit pointers, 32-bit memory words and a 32-bit narrow layout. This means one field is one word in the narrow layout and two words in the wide layout, so both word-splitting paths are exercised. The narrow buffer is five records deep with a threshold partway in, so random runs cover several wraps and a threshold crossing. The wide buffer sits above 2^32 with a threshold past its end, so the upper address words and the never-fires case are both checked. Random `memReady` stalls and configuration writes injected mid-record cover the hold and ignore rules.

// File: rtl/btrs_pkg.sv
package btrs_pkg;
  localparam int IdxW = 4;

  typedef enum logic [1:0] {
    StIdle,
    StSend,
    StStep
  } state_e;

  typedef struct packed {
    logic idle;
    logic capture;
    logic advance;
    logic [IdxW-1:0] wordIdx;
  } strobes_t;
endpackage

// File: rtl/btrs_ctrl.sv
module btrs_ctrl
  import btrs_pkg::*;
#(
  parameter int PTR_W    = 64,
  parameter int WORD_W   = 32,
  parameter int NARROW_W = 32
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     evValid,
  input  logic     memReady,
  input  logic     latWide,
  output strobes_t st,
  output logic     memValid,
  output logic     busy
);
  localparam int WideFw   = PTR_W / WORD_W;
  localparam int NarrowFw = NARROW_W / WORD_W;

  state_e          state;
  logic [IdxW-1:0] idx;
  logic [IdxW-1:0] lastIdx;

  assign lastIdx = latWide ? IdxW'(3 * WideFw - 1) : IdxW'(3 * NarrowFw - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= StIdle;
      idx   <= '0;
    end else begin
      case (state)
        StIdle: if (evValid) begin
          state <= StSend;
          idx   <= '0;
        end
        StSend: if (memReady) begin
          if (idx == lastIdx) state <= StStep;
          else idx <= idx + 1'b1;
        end
        default: state <= StIdle;
      endcase
    end
  end

  always_comb begin
    st.idle    = (state == StIdle);
    st.capture = (state == StIdle) && evValid;
    st.advance = (state == StStep);
    st.wordIdx = idx;
    memValid   = (state == StSend);
    busy       = (state != StIdle);
  end
endmodule

// File: rtl/btrs_datapath.sv
module btrs_datapath
  import btrs_pkg::*;
#(
  parameter int PTR_W    = 64,
  parameter int WORD_W   = 32,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic              layoutWide,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [PTR_W-1:0]  cfgData,
  input  logic              evInfo,
  input  logic [PTR_W-1:0]  evSrc,
  input  logic [PTR_W-1:0]  evDst,
  input  logic [7:0]        evType,
  input  logic [PTR_W-1:0]  evData,
  input  logic              irqClr,
  output logic              latWide,
  output logic [PTR_W-1:0]  memAddr,
  output logic [WORD_W-1:0] memData,
  output logic [PTR_W-1:0]  writePtr,
  output logic              irq
);
  localparam int WideFw   = PTR_W / WORD_W;
  localparam int NarrowFw = NARROW_W / WORD_W;
  localparam int ByteW    = WORD_W / 8;

  logic [PTR_W-1:0] baseQ, ptrQ, endQ, thrQ;
  logic             infoQ;
  logic [PTR_W-1:0] srcQ, dstQ, dataQ;
  logic [7:0]       typeQ;

  logic [PTR_W-1:0] mask, recBytes, baseM, ptrM, endM, thrM, nextPtr;
  logic [PTR_W-1:0] fieldVal;
  logic [IdxW-1:0]  fieldIdx, subIdx;
  logic             hit;

  always_comb begin
    mask     = latWide ? {PTR_W{1'b1}} : {{(PTR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    recBytes = latWide ? PTR_W'(3 * WideFw * ByteW) : PTR_W'(3 * NarrowFw * ByteW);
    baseM    = baseQ & mask;
    ptrM     = ptrQ & mask;
    endM     = endQ & mask;
    thrM     = thrQ & mask;
    nextPtr  = (ptrM + recBytes) & mask;
    hit      = (ptrM < thrM) && (nextPtr >= thrM) && (thrM <= endM);
  end

  // word index -> field and word within field
  always_comb begin
    if (latWide) begin
      fieldIdx = IdxW'(st.wordIdx / IdxW'(WideFw));
      subIdx   = IdxW'(st.wordIdx % IdxW'(WideFw));
    end else begin
      fieldIdx = IdxW'(st.wordIdx / IdxW'(NarrowFw));
      subIdx   = IdxW'(st.wordIdx % IdxW'(NarrowFw));
    end
    case (fieldIdx)
      IdxW'(0): fieldVal = infoQ ? {PTR_W{1'b1}} : srcQ;
      IdxW'(1): fieldVal = infoQ ? PTR_W'(typeQ) : dstQ;
      default:  fieldVal = infoQ ? dataQ : '0;
    endcase
    fieldVal = fieldVal & mask;
    memData  = fieldVal[subIdx*WORD_W +: WORD_W];
    memAddr  = (ptrQ + PTR_W'(st.wordIdx) * PTR_W'(ByteW)) & mask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0; ptrQ <= '0; endQ <= '0; thrQ <= '0;
      infoQ <= 1'b0; srcQ <= '0; dstQ <= '0; dataQ <= '0; typeQ <= '0;
      latWide <= 1'b0;
      irq <= 1'b0;
    end else begin
      if (cfgWe && st.idle) begin
        case (cfgSel)
          2'd0: baseQ <= cfgData;
          2'd1: ptrQ  <= cfgData;
          2'd2: endQ  <= cfgData;
          default: thrQ <= cfgData;
        endcase
      end
      if (st.capture) begin
        infoQ   <= evInfo;
        srcQ    <= evSrc;
        dstQ    <= evDst;
        typeQ   <= evType;
        dataQ   <= evData;
        latWide <= layoutWide;
      end
      if (st.advance) ptrQ <= (nextPtr >= endM) ? baseM : nextPtr;
      irq <= (st.advance && hit) || (irq && !irqClr);
    end
  end

  assign writePtr = ptrQ;
endmodule

// File: rtl/btrs_engine.sv
module btrs_engine
  import btrs_pkg::*;
#(
  parameter int PTR_W    = 64,
  parameter int WORD_W   = 32,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              layoutWide,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [PTR_W-1:0]  cfgData,
  input  logic              evValid,
  input  logic              evInfo,
  input  logic [PTR_W-1:0]  evSrc,
  input  logic [PTR_W-1:0]  evDst,
  input  logic [7:0]        evType,
  input  logic [PTR_W-1:0]  evData,
  input  logic              irqClr,
  input  logic              memReady,
  output logic              memValid,
  output logic [PTR_W-1:0]  memAddr,
  output logic [WORD_W-1:0] memData,
  output logic              busy,
  output logic              irq,
  output logic [PTR_W-1:0]  writePtr
);
  strobes_t st;
  logic     latWide;

  btrs_ctrl #(.PTR_W(PTR_W), .WORD_W(WORD_W), .NARROW_W(NARROW_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .evValid(evValid), .memReady(memReady),
    .latWide(latWide), .st(st), .memValid(memValid), .busy(busy)
  );

  btrs_datapath #(.PTR_W(PTR_W), .WORD_W(WORD_W), .NARROW_W(NARROW_W)) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .layoutWide(layoutWide),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .evInfo(evInfo), .evSrc(evSrc), .evDst(evDst), .evType(evType), .evData(evData),
    .irqClr(irqClr), .latWide(latWide), .memAddr(memAddr), .memData(memData),
    .writePtr(writePtr), .irq(irq)
  );
endmodule

// File: rtl/btrs_checker.sv
module btrs_checker #(
  parameter int PTR_W  = 64,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWe,
  input logic              irqClr,
  input logic              memReady,
  input logic              memValid,
  input logic [PTR_W-1:0]  memAddr,
  input logic [WORD_W-1:0] memData,
  input logic              busy,
  input logic              irq,
  input logic [PTR_W-1:0]  writePtr
);
  assert_req_in_record_R2: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> busy);

  assert_word_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memData)));

  assert_irq_from_advance_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $fell(busy));

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqClr) |=> irq);

  assert_ptr_moves_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(writePtr) |-> ($fell(busy) || $past(cfgWe && !busy)));
endmodule

bind btrs_engine btrs_checker #(.PTR_W(PTR_W), .WORD_W(WORD_W)) i_btrs_checker (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .irqClr(irqClr), .memReady(memReady),
  .memValid(memValid), .memAddr(memAddr), .memData(memData), .busy(busy),
  .irq(irq), .writePtr(writePtr)
);

// File: tb/test_btrs_engine.sv
module test_btrs_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        layoutWide = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [63:0] cfgData = '0;
  logic        evValid = 1'b0;
  logic        evInfo = 1'b0;
  logic [63:0] evSrc = '0, evDst = '0, evData = '0;
  logic [7:0]  evType = '0;
  logic        irqClr = 1'b0;
  logic        memReady = 1'b0;
  logic        memValid, busy, irq;
  logic [63:0] memAddr, writePtr;
  logic [31:0] memData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [63:0] mBase = '0, mPtr = '0, mEnd = '0, mThr = '0;
  bit          mIrq = 1'b0;

  btrs_engine i_btrs_engine (
    .clk(clk), .rstN(rstN), .layoutWide(layoutWide), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgData(cfgData), .evValid(evValid), .evInfo(evInfo), .evSrc(evSrc), .evDst(evDst),
    .evType(evType), .evData(evData), .irqClr(irqClr), .memReady(memReady),
    .memValid(memValid), .memAddr(memAddr), .memData(memData), .busy(busy),
    .irq(irq), .writePtr(writePtr)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] maskOf(input bit wide);
    return wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
  endfunction

  function automatic logic [31:0] expWord(input bit info, input bit wide, input logic [63:0] s,
                                          input logic [63:0] d, input logic [7:0] t,
                                          input logic [63:0] dat, input int k);
    int fw = wide ? 2 : 1;
    int f = k / fw;
    int sub = k % fw;
    logic [63:0] fv;
    if (f == 0)      fv = info ? 64'hFFFF_FFFF_FFFF_FFFF : s;
    else if (f == 1) fv = info ? {56'd0, t} : d;
    else             fv = info ? dat : 64'd0;
    fv = fv & maskOf(wide);
    return fv[sub*32 +: 32];
  endfunction

  task automatic cfgWrite(input logic [1:0] sel, input logic [63:0] val);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgData = val;
    @(negedge clk);
    cfgWe = 1'b0;
    case (sel)
      2'd0: mBase = val;
      2'd1: mPtr = val;
      2'd2: mEnd = val;
      default: mThr = val;
    endcase
  endtask

  task automatic clearIrq();
    @(negedge clk);
    irqClr = 1'b1;
    @(negedge clk);
    irqClr = 1'b0;
    mIrq = 1'b0;
    chk(irq == 1'b0, "R9 clear", {63'd0, irq}, 64'd0);
  endtask

  task automatic doEvent(input bit info, input logic [63:0] s, input logic [63:0] d,
                         input logic [7:0] t, input logic [63:0] dat, input bit intrude);
    bit wide = layoutWide;
    int nw = wide ? 6 : 3;
    int k = 0;
    logic [63:0] msk = maskOf(wide);
    logic [63:0] rb = wide ? 64'd24 : 64'd12;
    logic [63:0] nxt;
    string dreq = info ? "R5" : (wide ? "R4" : "R3");
    @(negedge clk);
    evValid = 1'b1; evInfo = info; evSrc = s; evDst = d; evType = t; evData = dat;
    @(negedge clk);
    evValid = 1'b0;
    chk(busy == 1'b1, "R2 busy", {63'd0, busy}, 64'd1);
    while (k < nw) begin
      bit acc;
      chk(memValid == 1'b1, "R2 valid", {63'd0, memValid}, 64'd1);
      chk(memAddr == ((mPtr + 64'(4 * k)) & msk), "R6 addr", memAddr, (mPtr + 64'(4 * k)) & msk);
      chk(memData == expWord(info, wide, s, d, t, dat, k), dreq, {32'd0, memData},
          {32'd0, expWord(info, wide, s, d, t, dat, k)});
      memReady = ($urandom % 3) != 0;
      if (intrude && k == 1) begin
        cfgWe = 1'b1; cfgSel = 2'd1; cfgData = 64'h0000_0000_00DE_AD00;
        evValid = 1'b1; evInfo = ~info; evSrc = ~s;
      end
      acc = memReady;
      @(negedge clk);
      memReady = 1'b0; cfgWe = 1'b0; evValid = 1'b0;
      if (acc) k++;
    end
    nxt = ((mPtr & msk) + rb) & msk;
    if (((mPtr & msk) < (mThr & msk)) && (nxt >= (mThr & msk)) && ((mThr & msk) <= (mEnd & msk)))
      mIrq = 1'b1;
    mPtr = (nxt >= (mEnd & msk)) ? (mBase & msk) : nxt;
    @(negedge clk);
    chk(busy == 1'b0, "R2 done", {63'd0, busy}, 64'd0);
    chk(writePtr == mPtr, "R7 pointer", writePtr, mPtr);
    chk(irq == mIrq, "R8 irq", {63'd0, irq}, {63'd0, mIrq});
    if (intrude) begin
      @(negedge clk);
      chk(memValid == 1'b0 && busy == 1'b0, "R10 R2 ignored while busy",
          {62'd0, memValid, busy}, 64'd0);
    end
  endtask

  task automatic randEvent();
    bit info = $urandom % 2;
    logic [63:0] s = {$urandom, $urandom};
    logic [63:0] d = {$urandom, $urandom};
    logic [63:0] dat = {$urandom, $urandom};
    logic [7:0] t = 8'($urandom);
    doEvent(info, s, d, t, dat, ($urandom % 4) == 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", {63'd0, busy}, 64'd0);
    chk(irq == 1'b0, "R1 irq", {63'd0, irq}, 64'd0);
    chk(memValid == 1'b0, "R1 memValid", {63'd0, memValid}, 64'd0);
    chk(writePtr == 64'd0, "R1 writePtr", writePtr, 64'd0);

    // narrow layout, five-record buffer, threshold after two records
    layoutWide = 1'b0;
    cfgWrite(2'd0, 64'h1000);
    cfgWrite(2'd1, 64'h1000);
    cfgWrite(2'd2, 64'h103C);
    cfgWrite(2'd3, 64'h1018);
    chk(writePtr == 64'h1000, "R10 cfg write", writePtr, 64'h1000);
    doEvent(1'b0, 64'hAAAA_BBBB_1111_2222, 64'h3333_4444_5555_6666, 8'h00, 64'h0, 1'b0);
    doEvent(1'b1, 64'h0, 64'h0, 8'h5A, 64'h9999_8888_7777_6666, 1'b1);
    chk(irq == 1'b1, "R8 crossing", {63'd0, irq}, 64'd1);
    doEvent(1'b0, 64'h10, 64'h20, 8'h00, 64'h0, 1'b0);
    chk(irq == 1'b1, "R9 sticky", {63'd0, irq}, 64'd1);
    clearIrq();
    for (int i = 0; i < 12; i++) randEvent();
    clearIrq();

    // wide layout above 4 GiB, threshold beyond end
    layoutWide = 1'b1;
    cfgWrite(2'd0, 64'h0000_0040_0000_2000);
    cfgWrite(2'd1, 64'h0000_0040_0000_2000);
    cfgWrite(2'd2, 64'h0000_0040_0000_2060);
    cfgWrite(2'd3, 64'h0000_0040_0000_2068);
    doEvent(1'b0, 64'hFEDC_BA98_7654_3210, 64'h0123_4567_89AB_CDEF, 8'h00, 64'h0, 1'b0);
    doEvent(1'b1, 64'h0, 64'h0, 8'hC3, 64'h1122_3344_5566_7788, 1'b0);
    for (int i = 0; i < 10; i++) randEvent();
    chk(irq == 1'b0, "R8 threshold beyond end", {63'd0, irq}, 64'd0);

    // threshold inside wide buffer
    cfgWrite(2'd3, 64'h0000_0040_0000_2030);
    for (int i = 0; i < 8; i++) randEvent();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule